// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable behavioural model of a synchronous static RAM with a registered read path and a short linear burst engine. Each word is 36 bits wide and is split into four 9-bit byte lanes. The depth is a parameter and defaults to 64 words. A new access begins when an address strobe is sampled low. Two strobes exist, one for a processor and one for a memory controller, and the processor strobe has fixed priority. Later accesses in the same burst are stepped by an advance input through a 2-bit counter. The counter is seeded from the low address bits and wraps inside the aligned four-word block.

Three chip enables decide whether the device is selected. They are sampled only on the cycle that loads a new address. The select state captured on that cycle holds until the next load. Writes come either from a global write that covers every lane or from a byte-write enable with one select per lane. Read data is registered and leaves on separate data-out pins, together with a valid flag that takes the place of a tristate pad. That flag follows the asynchronous output enable, with one exception: it is suppressed on the first read clock after a deselected state. A sleep input freezes all accesses and keeps the memory contents.

Top module: `sync_burst_sram`

## Requirements
- R1: While rst_ni is low, and after it rises, rvalid_o is low and the device is deselected until a load selects it.
- R2: A load happens when a recognised strobe is low. It selects the device only if ce1_ni=0, ce2_i=1 and ce3_ni=0, and it seeds the burst counter with addr_i[1:0]. A deselected device performs no reads or writes.
- R3: When adsp_ni and adsc_ni are both low with ce1_ni low, only the processor strobe acts. A processor-strobe load cycle is always a read, so gw_ni, bwe_ni and bw_ni are ignored in that cycle.
- R4: When ce1_ni is high, adsp_ni is ignored. With adsc_ni high, no load occurs and the current burst state is kept.
- R5: On cycles that do not load, the chip enables are ignored and the select state from the last load applies.
- R6: On a non-load cycle with adv_ni=0, the counter increments modulo 4 and the access uses it. The upper address bits stay fixed. With adv_ni=1, the same address is accessed again.
- R7: gw_ni=0 writes all four lanes, whatever bwe_ni and bw_ni hold.
- R8: With gw_ni=1 and bwe_ni=0, lane i (data bits 9i+8..9i) is written only when bw_ni[i]=0. A selected cycle that writes no lane is a read.
- R9: Read data for an access at a clock edge appears on rdata_o after that edge.
- R10: rvalid_o is low whenever oe_ni is high, and it follows oe_ni without waiting for a clock.
- R11: The first read after a deselected state gives rvalid_o=0, even with oe_ni low.
- R12: While zz_i is high, no read or write takes effect. The counter and select state hold, and rvalid_o goes low. Operation resumes on the first clock with zz_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | LANES | Per-lane write selects, active low |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| zz_i | input | 1 | Sleep, active high |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rvalid_o | output | 1 | Read data is being driven |

## Verification
The assertions check the following on every cycle: the oe_ni gate on rvalid_o, the masking rule linked to the select state before the read edge, counter seeding on a processor load, counter stepping on advance, select hold between loads, and the sleep freeze. The bench scenarios are needed for everything about data. This covers the exact word a wrapped burst reads back, which lanes a byte-write mask changes, the global-write override, and the write suppression under strobe priority, deselect and sleep. Each of these is only visible after the written data has been read back later.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/sram_addr_ctl.sv
`timescale 1ns/1ps
module sram_addr_ctl #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              zz_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_en_o,
  output logic              pload_o,
  output logic              sel_q_o,
  output logic [1:0]        cnt_q_o
);
  localparam int unsigned HI_W = ADDR_W - sram_pkg::BURST_W;

  logic [HI_W-1:0] base_q;
  logic [1:0]      cnt_q, cnt_d;
  logic            sel_q, sel_now;
  logic            p_ld, c_ld, ld;

  // processor strobe wins, and needs ce1 low to be seen at all
  assign p_ld    = !adsp_ni && !ce1_ni;
  assign c_ld    = !adsc_ni && !p_ld;
  assign ld      = p_ld || c_ld;
  assign sel_now = ld ? (!ce1_ni && ce2_i && !ce3_ni) : sel_q;
  assign cnt_d   = ld ? addr_i[1:0] : (adv_ni ? cnt_q : cnt_q + 2'd1);

  assign acc_addr_o = ld ? addr_i : {base_q, cnt_d};
  assign acc_en_o   = sel_now && !zz_i;
  assign pload_o    = p_ld;
  assign sel_q_o    = sel_q;
  assign cnt_q_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (!zz_i) begin
      sel_q <= sel_now;
      cnt_q <= cnt_d;
      if (ld) base_q <= addr_i[ADDR_W-1:sram_pkg::BURST_W];
    end
  end
endmodule

// File: rtl/sram_wr_decode.sv
`timescale 1ns/1ps
module sram_wr_decode #(
  parameter int unsigned LANES = sram_pkg::LANES
) (
  input  logic             pload_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] lane_we_o
);
  always_comb begin
    if (pload_i)      lane_we_o = '0;
    else if (!gw_ni)  lane_we_o = '1;
    else if (!bwe_ni) lane_we_o = ~bw_ni;
    else              lane_we_o = '0;
  end
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = sram_pkg::LANES,
  parameter int unsigned LANE_W = sram_pkg::LANE_W
) (
  input  logic                    clk_i,
  input  logic                    acc_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic rd_en;
  assign rd_en = acc_en_i && (lane_we_i == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (acc_en_i && lane_we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (rd_en) rd_q <= mem[addr_i];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = sram_pkg::LANES,
  parameter int unsigned LANE_W = sram_pkg::LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    oe_ni,
  input  logic                    zz_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_en, pload, sel_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  lane_we;
  logic              rd_q, first_q;

  sram_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i, .rst_ni, .addr_i, .ce1_ni, .ce2_i, .ce3_ni,
    .adsp_ni, .adsc_ni, .adv_ni, .zz_i,
    .acc_addr_o(acc_addr), .acc_en_o(acc_en), .pload_o(pload),
    .sel_q_o(sel_q), .cnt_q_o(cnt_q)
  );

  sram_wr_decode #(.LANES(LANES)) u_wr (
    .pload_i(pload), .gw_ni, .bwe_ni, .bw_ni, .lane_we_o(lane_we)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i, .acc_en_i(acc_en), .addr_i(acc_addr), .lane_we_i(lane_we),
    .wdata_i, .rdata_o
  );

  // output stage: a read coming straight out of deselect stays masked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      first_q <= 1'b0;
    end else begin
      rd_q    <= acc_en && (lane_we == '0);
      first_q <= acc_en && (lane_we == '0) && !sel_q;
    end
  end

  assign rvalid_o = rd_q && !first_q && !oe_ni;
endmodule

// File: rtl/sync_burst_sram_chk.sv
`timescale 1ns/1ps
module sync_burst_sram_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce1_ni,
  input logic              adsp_ni,
  input logic              adsc_ni,
  input logic              adv_ni,
  input logic              oe_ni,
  input logic              zz_i,
  input logic              rvalid_o,
  input logic              sel_q,
  input logic [1:0]        cnt_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i) !rst_ni |=> !rvalid_o);

  assert_seed_on_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce1_ni && !zz_i) |=> cnt_q == $past(addr_i[1:0]));

  assert_adsp_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && ce1_ni && adsc_ni && !zz_i) |=> $stable(sel_q));

  assert_sel_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsp_ni && adsc_ni) |=> $stable(sel_q));

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsp_ni && adsc_ni && !adv_ni && !zz_i) |=> cnt_q == 2'($past(cnt_q) + 2'd1));

  assert_oe_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rvalid_o);

  assert_first_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(sel_q));

  assert_sleep_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |=> ($stable(cnt_q) && $stable(sel_q) && !rvalid_o));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .ce1_ni, .adsp_ni, .adsc_ni, .adv_ni,
  .oe_ni, .zz_i, .rvalid_o, .sel_q, .cnt_q
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int AW = 6;
  localparam int W  = 36;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i;
  logic          ce1_ni, ce2_i, ce3_ni, adsp_ni, adsc_ni, adv_ni;
  logic          gw_ni, bwe_ni, oe_ni, zz_i;
  logic [3:0]    bw_ni;
  logic [W-1:0]  wdata_i, rdata_o;
  logic          rvalid_o;

  logic [W-1:0]  ref_m [64];
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #2.5 clk_i = ~clk_i;

  sync_burst_sram #(.ADDR_W(AW)) u_dut (.*);

  function automatic logic [W-1:0] pat(input int a, input int g);
    return W'(a * 36'h1_F3D5_B79 + g * 36'h0_0777_123) ^ 36'hA_5A5A_5A5A;
  endfunction

  task automatic idle();
    addr_i = '0; ce1_ni = 0; ce2_i = 1; ce3_ni = 0;
    adsp_ni = 1; adsc_ni = 1; adv_ni = 1;
    gw_ni = 1; bwe_ni = 1; bw_ni = 4'hF; oe_ni = 0; zz_i = 0; wdata_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input logic exp_v, input logic [W-1:0] exp_d);
    n_chk++;
    if (rvalid_o !== exp_v || (exp_v && rdata_o !== exp_d)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               req, rvalid_o, rdata_o, exp_v, exp_d);
    end
  endtask

  task automatic load_p(input int a);
    idle(); adsp_ni = 0; addr_i = AW'(a); tick();
  endtask

  task automatic deselect();
    idle(); adsc_ni = 0; ce2_i = 0; tick();
  endtask

  initial begin
    idle();
    repeat (3) tick();
    chk("R1", 0, '0);
    rst_ni = 1; tick();
    chk("R1", 0, '0);

    // R7: fill every word through global-write bursts, wrapping start offsets
    for (int b = 0; b < 16; b++) begin
      for (int i = 0; i < 4; i++) begin
        int a;
        a = b * 4 + ((b + i) % 4);
        idle(); gw_ni = 0; bwe_ni = 0; bw_ni = 4'hF;
        if (i == 0) adsc_ni = 0; else adv_ni = 0;
        addr_i = AW'(a); wdata_i = pat(a, 0); ref_m[a] = pat(a, 0);
        tick();
      end
    end
    chk("R7", 0, '0);

    // R6 R9 R11: read bursts, deselect before every fourth block
    for (int b = 0; b < 16; b++) begin
      if (b % 4 == 0) begin deselect(); chk("R2", 0, '0); end
      load_p(b * 4 + ((b + 1) % 4));
      chk((b % 4 == 0) ? "R11" : "R9", (b % 4 != 0), ref_m[b * 4 + ((b + 1) % 4)]);
      for (int i = 1; i < 4; i++) begin
        idle(); adv_ni = 0; tick();
        chk("R6", 1, ref_m[b * 4 + ((b + 1 + i) % 4)]);
      end
    end

    // R8: every lane mask
    for (int p = 0; p < 16; p++) begin
      int a;
      a = p * 4 + 1;
      idle(); adsc_ni = 0; addr_i = AW'(a); bwe_ni = 0; bw_ni = 4'(p);
      wdata_i = ~ref_m[a];
      for (int l = 0; l < 4; l++) if (!p[l]) ref_m[a][l*9 +: 9] = wdata_i[l*9 +: 9];
      tick();
      chk("R8", (p == 15), ref_m[a]);
    end
    for (int p = 0; p < 16; p++) begin
      load_p(p * 4 + 1); chk("R8", 1, ref_m[p * 4 + 1]);
    end
    idle(); adsc_ni = 0; addr_i = 6'd5; tick();
    chk("R8", 1, ref_m[5]);

    // R7: global write overrides disabled byte writes
    idle(); adsc_ni = 0; addr_i = 6'd2; gw_ni = 0; bwe_ni = 1; bw_ni = 4'hF;
    wdata_i = pat(2, 7); ref_m[2] = pat(2, 7); tick();
    load_p(2); chk("R7", 1, ref_m[2]);

    // R3: both strobes low, processor wins, write controls ignored
    idle(); adsp_ni = 0; adsc_ni = 0; addr_i = 6'd3; gw_ni = 0; wdata_i = pat(3, 9); tick();
    chk("R3", 1, ref_m[3]);
    load_p(3); chk("R3", 1, ref_m[3]);

    // R4: processor strobe with ce1 high is ignored
    load_p(8); chk("R4", 1, ref_m[8]);
    idle(); adsp_ni = 0; ce1_ni = 1; addr_i = 6'd40; tick();
    chk("R4", 1, ref_m[8]);

    // R5: chip enables ignored between loads
    load_p(12);
    idle(); ce2_i = 0; ce3_ni = 1; adv_ni = 0; tick();
    chk("R5", 1, ref_m[13]);

    // R6: advance high repeats the address
    load_p(17); idle(); tick(); chk("R6", 1, ref_m[17]);

    // R10: output enable gates asynchronously
    idle(); adsp_ni = 0; addr_i = 6'd21; oe_ni = 1; tick();
    chk("R10", 0, '0);
    oe_ni = 0; #1;
    chk("R10", 1, ref_m[21]);

    // R11: controller-strobe read right after deselect is masked
    deselect();
    idle(); adsc_ni = 0; addr_i = 6'd22; tick(); chk("R11", 0, '0);
    idle(); adv_ni = 0; tick(); chk("R11", 1, ref_m[23]);

    // R2: deselected load and burst do not write
    idle(); adsc_ni = 0; ce3_ni = 1; addr_i = 6'd30; gw_ni = 0; wdata_i = pat(30, 5); tick();
    chk("R2", 0, '0);
    idle(); adv_ni = 0; gw_ni = 0; wdata_i = pat(31, 5); tick();
    chk("R2", 0, '0);
    load_p(30); chk("R11", 0, '0);
    load_p(30); chk("R2", 1, ref_m[30]);
    idle(); adv_ni = 0; tick(); chk("R2", 1, ref_m[31]);

    // R12: sleep blocks writes and freezes the counter
    idle(); zz_i = 1; adsc_ni = 0; addr_i = 6'd20; gw_ni = 0; wdata_i = pat(20, 3); tick();
    chk("R12", 0, '0);
    load_p(20); chk("R12", 1, ref_m[20]);
    load_p(24);
    idle(); adv_ni = 0; tick(); chk("R6", 1, ref_m[25]);
    idle(); adv_ni = 0; zz_i = 1; tick(); chk("R12", 0, '0);
    idle(); adv_ni = 0; tick(); chk("R12", 1, ref_m[26]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: valid=%0b data=%h expected valid=1 data=end of run",
               rvalid_o, rdata_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule